// File: doc/BRIEF.md
# Power-On Strap Capture with Shared Mode/Suspend Pin

This block reads board-level configuration straps from pins that are reused for other jobs once the chip is running. A fixed number of clock cycles after reset is released, it samples every strap at once and stores a decoded copy. The stored values are the power-switch grouping (ganged or per port), the power-enable polarity, the number of active downstream ports, one non-removable flag per port and the reference clock source. The stored copy does not change again until the next reset.

One pin serves two purposes. Right after reset it is an input that carries the grouping strap. A second, longer interval after the sample point, the block turns the pin into an output that reports global suspend. The output level depends on the captured grouping. In ganged mode the pin drives low in normal operation and high while suspended. In per-port mode it drives high in normal operation and low while suspended. This way the level the pin drives matches the level its external strap resistor pulls toward when the chip is suspended. The block supplies the pin's output enable and output value; the pad itself lies outside the block.

Top module: `strap_capture`

## Requirements
- R1: While reset is asserted, and after release until the sample point, `cfg_valid_o` and `pin_oe_o` are 0.
- R2: All straps are captured on the SAMPLE_CYC-th rising clock edge after reset is released. `cfg_valid_o` goes to 1 on that same edge.
- R3: `gang_o` takes the value the shared pin had at the sample point: 1 selects ganged power control and 0 selects per-port control.
- R4: `pin_oe_o` goes to 1 exactly TURN_CYC clock edges after the sample edge, and it stays at 1 until the next reset.
- R5: While `pin_oe_o` is 1, `pin_out_o` equals `gsusp_i` in ganged mode and the inverse of `gsusp_i` in per-port mode.
- R6: `port_cnt_o` decodes the two-bit count strap as follows: 2'b10 gives 2 ports, 2'b01 gives 3 ports, and 2'b00 or the reserved 2'b11 gives 4 ports.
- R7: Bit i of `nonrem_o` is the value of `green_strap_i[i]` at the sample point; a 1 marks port i as non-removable.
- R8: `clksel_o` decodes the clock strap as follows: 2'b01 gives code 1 (48 MHz oscillator), 2'b10 gives code 2 (27 MHz oscillator), and 2'b11 or the reserved 2'b00 gives code 0 (12 MHz crystal). Code 3 never appears.
- R9: `pol_o` takes the value of `pol_strap_i` at the sample point.
- R10: Any change to a strap input after the sample point leaves every configuration output unchanged until the next reset.
- R11: While `pin_oe_o` is 0, `pin_out_o` is 0 whatever the value of `gsusp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin_i | input | 1 | Input value of the shared grouping/suspend pin |
| pol_strap_i | input | 1 | Enable-polarity strap |
| cnt_strap_i | input | 2 | Port-count strap |
| green_strap_i | input | NPORT | Per-port non-removable straps |
| clk_strap_i | input | 2 | Reference clock strap |
| gsusp_i | input | 1 | Global suspend |
| cfg_valid_o | output | 1 | Straps have been captured |
| gang_o | output | 1 | 1 = ganged, 0 = per-port power control |
| pol_o | output | 1 | Captured enable polarity |
| port_cnt_o | output | 3 | Number of active ports |
| nonrem_o | output | NPORT | Non-removable flags |
| clksel_o | output | 2 | Clock source code |
| pin_oe_o | output | 1 | Output enable of the shared pin |
| pin_out_o | output | 1 | Output value of the shared pin |

## Verification
On every cycle, the assertions check the following: the pin stays undriven until a capture has happened, the output enable never drops once set, the driven level follows suspend with the polarity set by the grouping strap, the captured values stay frozen, and the two decoded fields never take an illegal code. The exact sample cycle, the exact turnaround cycle and the decoded value for each strap pattern can only be shown by the bench. It runs a table of strap patterns, which includes both reserved codes, through full reset sequences. It then disturbs the straps after capture and resets in the middle of the drive phase.

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NPORT      = 4,
  parameter int SAMPLE_CYC = 240,
  parameter int TURN_CYC   = 600000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pin_i,
  input  logic             pol_strap_i,
  input  logic [1:0]       cnt_strap_i,
  input  logic [NPORT-1:0] green_strap_i,
  input  logic [1:0]       clk_strap_i,
  input  logic             gsusp_i,
  output logic             cfg_valid_o,
  output logic             gang_o,
  output logic             pol_o,
  output logic [2:0]       port_cnt_o,
  output logic [NPORT-1:0] nonrem_o,
  output logic [1:0]       clksel_o,
  output logic             pin_oe_o,
  output logic             pin_out_o
);

  localparam int MAXC = (SAMPLE_CYC > TURN_CYC) ? SAMPLE_CYC : TURN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] TURN_LAST   = CW'(TURN_CYC - 1);

  typedef enum logic [1:0] {PH_WAIT, PH_HOLD, PH_DRIVE} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          sample;

  assign sample = (phase == PH_WAIT) && (cnt == SAMPLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (cnt == SAMPLE_LAST) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_HOLD: begin
          if (cnt == TURN_LAST) begin
            phase <= PH_DRIVE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  function automatic logic [2:0] ports_of(input logic [1:0] s);
    case (s)
      2'b10:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] clk_of(input logic [1:0] s);
    case (s)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid_o <= 1'b0;
      gang_o      <= 1'b0;
      pol_o       <= 1'b0;
      port_cnt_o  <= 3'd0;
      nonrem_o    <= '0;
      clksel_o    <= 2'd0;
    end else if (sample) begin
      cfg_valid_o <= 1'b1;
      gang_o      <= mode_pin_i;
      pol_o       <= pol_strap_i;
      port_cnt_o  <= ports_of(cnt_strap_i);
      nonrem_o    <= green_strap_i;
      clksel_o    <= clk_of(clk_strap_i);
    end
  end

  assign pin_oe_o  = (phase == PH_DRIVE);
  assign pin_out_o = pin_oe_o & ~(gsusp_i ^ gang_o);

  p_quiet_before_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid_o |-> !pin_oe_o);

  p_oe_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |=> pin_oe_o);

  p_oe_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe_o) |-> (cfg_valid_o && $past(cfg_valid_o)));

  p_gang_suspend_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && gang_o) |-> (pin_out_o == gsusp_i));

  p_indiv_suspend_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_o && !gang_o) |-> (pin_out_o != gsusp_i));

  p_port_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> (port_cnt_o >= 3'd2 && port_cnt_o <= 3'd4));

  p_clk_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clksel_o != 2'd3);

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |=> ($stable(gang_o) && $stable(pol_o) && $stable(port_cnt_o)
                     && $stable(nonrem_o) && $stable(clksel_o) && cfg_valid_o));

  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o |-> !pin_out_o);

endmodule

// File: tb/sim_strap_capture.sv
module sim_strap_capture;
  localparam int NP = 4;
  localparam int SC = 8;
  localparam int TC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin, pol_s, gsusp;
  logic [1:0] cnt_s, clk_s;
  logic [NP-1:0] grn_s;
  logic valid, gang, pol, oe, pout;
  logic [2:0] ports;
  logic [NP-1:0] nonrem;
  logic [1:0] csel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  strap_capture #(.NPORT(NP), .SAMPLE_CYC(SC), .TURN_CYC(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pin_i(mode_pin), .pol_strap_i(pol_s),
    .cnt_strap_i(cnt_s), .green_strap_i(grn_s), .clk_strap_i(clk_s),
    .gsusp_i(gsusp), .cfg_valid_o(valid), .gang_o(gang), .pol_o(pol),
    .port_cnt_o(ports), .nonrem_o(nonrem), .clksel_o(csel),
    .pin_oe_o(oe), .pin_out_o(pout));

  // {mode,pol,cnt[1:0],green[3:0],clk[1:0], gang,pol,ports[2:0],nonrem[3:0],clksel[1:0]}
  localparam logic [20:0] VEC [6] = '{
    21'b1_0_00_0000_11_1_0_100_0000_00,
    21'b0_1_10_1010_01_0_1_010_1010_01,
    21'b1_1_01_0101_10_1_1_011_0101_10,
    21'b0_0_11_1111_00_0_0_100_1111_00,
    21'b1_0_00_0001_01_1_0_100_0001_01,
    21'b0_1_01_1000_10_0_1_011_1000_10
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cfg(input logic [10:0] e, input string tag);
    chk(gang == e[10], {"R3 gang ", tag}, gang, e[10]);
    chk(pol == e[9], {"R9 pol ", tag}, pol, e[9]);
    chk(ports == e[8:6], {"R6 ports ", tag}, ports, e[8:6]);
    chk(nonrem == e[5:2], {"R7 nonrem ", tag}, nonrem, e[5:2]);
    chk(csel == e[1:0], {"R8 clksel ", tag}, csel, e[1:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    {mode_pin, pol_s, cnt_s, grn_s, clk_s, gsusp} = '0;
    step(3);
    chk(!valid && !oe && !pout, "R1 reset state", {valid, oe}, 0);

    foreach (VEC[i]) begin
      rst_n = 1'b0;
      {mode_pin, pol_s, cnt_s, grn_s, clk_s} = VEC[i][20:11];
      gsusp = 1'b0;
      step(2);
      chk(!valid && !oe, "R1 in reset", {valid, oe}, 0);
      rst_n = 1'b1;
      step(SC - 1);
      chk(!valid && !oe, "R1 before sample", {valid, oe}, 0);
      step(1);
      chk(valid, "R2 sample edge", valid, 1);
      check_cfg(VEC[i][10:0], "capture");
      // R10: disturb all straps after capture
      {mode_pin, pol_s, cnt_s, grn_s, clk_s} = ~VEC[i][20:11];
      gsusp = 1'b1;
      step(TC - 1);
      chk(!oe, "R4 before turnaround", oe, 0);
      chk(!pout, "R11 idle with suspend", pout, 0);
      step(1);
      chk(oe, "R4 turnaround edge", oe, 1);
      chk(pout == VEC[i][10], "R5 suspended level", pout, VEC[i][10]);
      gsusp = 1'b0;
      step(1);
      chk(pout == !VEC[i][10], "R5 normal level", pout, !VEC[i][10]);
      chk(oe, "R4 stays driven", oe, 1);
      check_cfg(VEC[i][10:0], "R10 after disturb");
    end

    // reset in the middle of the drive phase
    rst_n = 1'b0;
    gsusp = 1'b1;
    step(1);
    chk(!oe && !valid && !pout, "R1 reset mid-drive", {valid, oe, pout}, 0);
    chk(gang == 1'b0 && ports == 3'd0, "R1 cleared config", ports, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule